// File: doc/BRIEF.md
# Privilege-Gated Trace Output Qualifier

This block decides, for each of several harts, whether the instruction trace encoder may emit trace for the instruction currently retiring. It combines three inputs: the hart's privilege context, an M-mode trace enable supplied from outside the hart, and a supervisor-domain allow bit. The M-mode enable is set by a root of trust, and software cannot change it. The allow bit is writable by software and sits in a machine-level domain configuration register. From these the block produces a security-inhibit sideband for the trace encoder, which travels alongside the hart's halted indication.

The M-mode enable opens trace everywhere, in M-mode and in the supervisor domain. The allow bit opens trace only outside M-mode. When both are clear, trace is shut at every privilege level. A hart that is halted always reports halted rather than inhibit, so the pair {inhibit, halted} never takes the reserved value 2'b11.

Two build options change the block's shape. The first lets one enable serve every hart or gives each hart its own enable. The second targets a trace encoder with no inhibit input: in that case suppression is signalled by raising halted instead of inhibit.

Top module: `trc_priv_gate`

## Requirements
- R1: While reset is active and on the first cycle after it, every hart reports inhibit 0, halted 0 and a stored allow bit of 0.
- R2: If a hart's M-mode enable was 1 and the hart was not halted, its inhibit output is 0 whatever the privilege mode.
- R3: With the inhibit sideband built in, if the M-mode enable was 0, the hart was in M-mode (mode code 2'b11) and not halted, inhibit is 1.
- R4: With the inhibit sideband built in, in any mode code other than 2'b11 and not halted, inhibit equals NOT(allow OR M-mode enable).
- R5: The allow bit is taken from bit 8 of the write data, and only when the write enable is set while the hart is in mode 2'b11. Writes in other modes and all other data bits leave it unchanged. Its value is visible on csr_allow_o, and it resets to 0.
- R6: A halted hart reports halted 1 and inhibit 0, so {inhibit, halted} is never 2'b11.
- R7: Without the inhibit sideband, inhibit_o stays 0 and halted_o is 1 when the hart is halted or when trace would have been blocked.
- R8: With the shared-enable option, the single enable bit governs every hart in the same way.
- R9: The sideband outputs are registered. They reflect the mode, enable, halt and stored allow value present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mtrace_en_i | input | SHARED_EN ? 1 : NUM_HARTS | M-mode trace enable from the root of trust |
| priv_i | input | 2*NUM_HARTS | Per-hart privilege mode of the retiring instruction (2'b11 = M-mode) |
| halt_i | input | NUM_HARTS | Per-hart halted state |
| csr_we_i | input | NUM_HARTS | Per-hart write strobe for the domain configuration register |
| csr_wdata_i | input | CSR_W*NUM_HARTS | Per-hart write data; bit 8 of each slice is the allow bit |
| csr_allow_o | output | NUM_HARTS | Stored supervisor-domain allow bit per hart |
| inhibit_o | output | NUM_HARTS | Registered security-inhibit sideband to the trace encoder |
| halted_o | output | NUM_HARTS | Registered halted indication to the trace encoder |

## Verification
Two functions can act in the same cycle: a hart being halted and the security block condition both being true. Halt has to win without the reserved 2'b11 pair ever appearing. The bench provokes this by raising halt while the M-mode enable is 0 in M-mode, and also while both enables are 0 in supervisor context. A second collision is an allow-bit write landing in the same cycle as a mode change. It is judged by the rule that the write only counts if the mode at that edge is 2'b11, and by the one-cycle delay before the stored bit reaches the sideband. A behavioural model predicts both pairs on every clock, for the default build and for a shared-enable build with no inhibit input.

// File: rtl/trc_gate_pkg.sv
package trc_gate_pkg;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef struct packed {
    logic inhibit;
    logic halted;
  } trc_sb_t;

  function automatic logic in_machine(input logic [1:0] p);
    return p == PRIV_MACHINE;
  endfunction
endpackage

// File: rtl/trc_allow_csr.sv
module trc_allow_csr #(
  parameter int CSR_W     = 64,
  parameter int ALLOW_POS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       priv,
  input  logic [CSR_W-1:0] wdata,
  output logic             allow_o
);
  import trc_gate_pkg::*;

  logic unused_bits;
  assign unused_bits = ^{wdata[CSR_W-1:ALLOW_POS+1], wdata[ALLOW_POS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_o <= 1'b0;
    end else if (wr_en && in_machine(priv)) begin
      allow_o <= wdata[ALLOW_POS];
    end
  end
endmodule

// File: rtl/trc_grant_logic.sv
module trc_grant_logic (
  input  logic       m_en,
  input  logic       allow,
  input  logic [1:0] priv,
  output logic       block
);
  import trc_gate_pkg::*;

  always_comb begin
    if (in_machine(priv)) begin
      block = ~m_en;
    end else begin
      block = ~(m_en | allow);
    end
  end
endmodule

// File: rtl/trc_sideband_enc.sv
module trc_sideband_enc #(
  parameter bit HAS_INHIBIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic block,
  input  logic halt,
  output logic inhibit_o,
  output logic halted_o
);
  import trc_gate_pkg::*;

  trc_sb_t sb_d, sb_q;

  generate
    if (HAS_INHIBIT) begin : g_sideband
      always_comb begin
        sb_d.inhibit = block & ~halt;
        sb_d.halted  = halt;
      end
    end else begin : g_halt_only
      always_comb begin
        sb_d.inhibit = 1'b0;
        sb_d.halted  = halt | block;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_q <= '0;
    end else begin
      sb_q <= sb_d;
    end
  end

  assign inhibit_o = sb_q.inhibit;
  assign halted_o  = sb_q.halted;
endmodule

// File: rtl/trc_priv_gate.sv
module trc_priv_gate #(
  parameter int NUM_HARTS   = 4,
  parameter bit SHARED_EN   = 1'b0,
  parameter bit HAS_INHIBIT = 1'b1,
  parameter int CSR_W       = 64,
  parameter int ALLOW_POS   = 8,
  localparam int EN_W       = SHARED_EN ? 1 : NUM_HARTS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [EN_W-1:0]            mtrace_en_i,
  input  logic [2*NUM_HARTS-1:0]     priv_i,
  input  logic [NUM_HARTS-1:0]       halt_i,
  input  logic [NUM_HARTS-1:0]       csr_we_i,
  input  logic [CSR_W*NUM_HARTS-1:0] csr_wdata_i,
  output logic [NUM_HARTS-1:0]       csr_allow_o,
  output logic [NUM_HARTS-1:0]       inhibit_o,
  output logic [NUM_HARTS-1:0]       halted_o
);
  logic [NUM_HARTS-1:0] hart_en;
  logic [NUM_HARTS-1:0] block;

  generate
    if (SHARED_EN) begin : g_en_shared
      assign hart_en = {NUM_HARTS{mtrace_en_i[0]}};
    end else begin : g_en_private
      assign hart_en = mtrace_en_i;
    end
  endgenerate

  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      trc_allow_csr #(.CSR_W(CSR_W), .ALLOW_POS(ALLOW_POS)) csr_u (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (csr_we_i[h]),
        .priv    (priv_i[2*h +: 2]),
        .wdata   (csr_wdata_i[CSR_W*h +: CSR_W]),
        .allow_o (csr_allow_o[h])
      );

      trc_grant_logic grant_u (
        .m_en  (hart_en[h]),
        .allow (csr_allow_o[h]),
        .priv  (priv_i[2*h +: 2]),
        .block (block[h])
      );

      trc_sideband_enc #(.HAS_INHIBIT(HAS_INHIBIT)) enc_u (
        .clk       (clk),
        .rst       (rst),
        .block     (block[h]),
        .halt      (halt_i[h]),
        .inhibit_o (inhibit_o[h]),
        .halted_o  (halted_o[h])
      );
    end
  endgenerate
endmodule

// File: rtl/trc_priv_gate_chk.sv
module trc_priv_gate_chk #(
  parameter int NUM_HARTS   = 4,
  parameter bit SHARED_EN   = 1'b0,
  parameter bit HAS_INHIBIT = 1'b1,
  parameter int CSR_W       = 64,
  localparam int EN_W       = SHARED_EN ? 1 : NUM_HARTS
) (
  input logic                       clk,
  input logic                       rst,
  input logic [EN_W-1:0]            mtrace_en_i,
  input logic [2*NUM_HARTS-1:0]     priv_i,
  input logic [NUM_HARTS-1:0]       halt_i,
  input logic [NUM_HARTS-1:0]       csr_we_i,
  input logic [CSR_W*NUM_HARTS-1:0] csr_wdata_i,
  input logic [NUM_HARTS-1:0]       csr_allow_o,
  input logic [NUM_HARTS-1:0]       inhibit_o,
  input logic [NUM_HARTS-1:0]       halted_o
);
  logic unused_wdata;
  assign unused_wdata = ^csr_wdata_i;

  // R6
  no_reserved_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (inhibit_o & halted_o) == '0);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
    logic en_h;
    assign en_h = SHARED_EN ? mtrace_en_i[0] : mtrace_en_i[h % EN_W];

    // R6
    halt_wins_chk: assert property (@(posedge clk) disable iff (rst)
      halt_i[h] |=> (halted_o[h] && !inhibit_o[h]));

    // R2
    men_opens_chk: assert property (@(posedge clk) disable iff (rst)
      (en_h && !halt_i[h]) |=> (!inhibit_o[h] && !halted_o[h]));

    // R5
    write_outside_m_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (csr_we_i[h] && priv_i[2*h +: 2] != 2'b11) |=> $stable(csr_allow_o[h]));

    if (HAS_INHIBIT) begin : g_inh
      // R3
      m_mode_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_h && priv_i[2*h +: 2] == 2'b11 && !halt_i[h]) |=> inhibit_o[h]);
    end else begin : g_noinh
      // R7
      halt_substitute_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_h && priv_i[2*h +: 2] == 2'b11) |=> (halted_o[h] && !inhibit_o[h]));
    end
  end
endmodule

bind trc_priv_gate trc_priv_gate_chk #(
  .NUM_HARTS(NUM_HARTS), .SHARED_EN(SHARED_EN),
  .HAS_INHIBIT(HAS_INHIBIT), .CSR_W(CSR_W)
) chk_i (
  .clk(clk), .rst(rst), .mtrace_en_i(mtrace_en_i), .priv_i(priv_i),
  .halt_i(halt_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
  .csr_allow_o(csr_allow_o), .inhibit_o(inhibit_o), .halted_o(halted_o)
);

// File: tb/trc_priv_gate_tb_top.sv
module trc_priv_gate_tb_top;
  localparam int N = 4;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   men = '0;
  logic           men_sh = 1'b0;
  logic [2*N-1:0] priv = '0;
  logic [N-1:0]   halt = '0;
  logic [N-1:0]   we = '0;
  logic [W*N-1:0] wdata = '0;

  logic [N-1:0] allow0, inh0, hlt0, allow1, inh1, hlt1;

  always #2 clk = ~clk;

  trc_priv_gate #(.NUM_HARTS(N), .CSR_W(W)) dut_i (
    .clk(clk), .rst(rst), .mtrace_en_i(men), .priv_i(priv), .halt_i(halt),
    .csr_we_i(we), .csr_wdata_i(wdata), .csr_allow_o(allow0),
    .inhibit_o(inh0), .halted_o(hlt0)
  );

  trc_priv_gate #(.NUM_HARTS(N), .SHARED_EN(1'b1), .HAS_INHIBIT(1'b0), .CSR_W(W)) dut_alt (
    .clk(clk), .rst(rst), .mtrace_en_i(men_sh), .priv_i(priv), .halt_i(halt),
    .csr_we_i(we), .csr_wdata_i(wdata), .csr_allow_o(allow1),
    .inhibit_o(inh1), .halted_o(hlt1)
  );

  // behavioural reference, advanced on each rising edge
  bit      m_allow [N];
  bit      e_inh0 [N], e_hlt0 [N], e_inh1 [N], e_hlt1 [N];
  string   tag0 [N];
  string   tag1 [N];
  int      compared = 0;
  int      mismatched = 0;
  bit      started = 0;

  always @(posedge clk) begin
    for (int h = 0; h < N; h++) begin
      if (rst) begin
        e_inh0[h] = 0; e_hlt0[h] = 0; e_inh1[h] = 0; e_hlt1[h] = 0;
        m_allow[h] = 0;
        tag0[h] = "R1"; tag1[h] = "R1";
      end else begin
        bit is_m, blk0, blk1;
        is_m = (priv[2*h +: 2] == 2'b11);
        blk0 = is_m ? !men[h] : !(men[h] || m_allow[h]);
        blk1 = is_m ? !men_sh : !(men_sh || m_allow[h]);
        e_hlt0[h] = halt[h];
        e_inh0[h] = blk0 && !halt[h];
        e_hlt1[h] = halt[h] || blk1;
        e_inh1[h] = 0;
        if (halt[h]) tag0[h] = "R6";
        else if (men[h]) tag0[h] = "R2";
        else if (is_m) tag0[h] = "R3";
        else tag0[h] = "R4";
        tag1[h] = "R7,R8";
        if (we[h] && is_m) m_allow[h] = wdata[W*h + 8];
      end
    end
    started = 1;
  end

  task automatic cmp(input string tag, input logic act, input bit exp, input int h);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s hart %0d t=%0t actual=%b expected=%b", tag, h, $time, act, exp);
    end
  endtask

  task automatic check_all();
    for (int h = 0; h < N; h++) begin
      cmp({tag0[h], ",R9 inhibit"}, inh0[h], e_inh0[h], h);
      cmp({tag0[h], ",R9 halted"},  hlt0[h], e_hlt0[h], h);
      cmp({tag1[h], " inhibit"},    inh1[h], e_inh1[h], h);
      cmp({tag1[h], " halted"},     hlt1[h], e_hlt1[h], h);
      cmp("R5 allow", allow0[h], m_allow[h], h);
      cmp("R5 allow alt", allow1[h], m_allow[h], h);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (started) check_all();
  endtask

  task automatic set_all(input logic [1:0] p, input logic [N-1:0] e, input logic es,
                         input logic [N-1:0] hl);
    for (int h = 0; h < N; h++) priv[2*h +: 2] = p;
    men = e; men_sh = es; halt = hl;
  endtask

  task automatic write_all(input logic b8, input logic others);
    we = '1;
    for (int h = 0; h < N; h++) begin
      wdata[W*h +: W] = {W{others}};
      wdata[W*h + 8] = b8;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    repeat (3) step();
    rst = 1'b0;
    step();
    // R2: enable on, every mode
    for (int p = 0; p < 4; p++) begin
      set_all(p[1:0], '1, 1'b1, '0);
      step();
    end
    // R3: M-mode with enable off
    set_all(2'b11, '0, 1'b0, '0);
    step(); step();
    // R5: write attempted outside M-mode, bit 8 set
    set_all(2'b01, '0, 1'b0, '0);
    write_all(1'b1, 1'b0);
    step();
    we = '0;
    // R4: supervisor context, allow 0
    step(); step();
    // R5: M-mode write, other bits set but bit 8 clear
    set_all(2'b11, '0, 1'b0, '0);
    write_all(1'b0, 1'b1);
    step();
    // R5: M-mode write of bit 8 only, mode changes in same cycle after
    write_all(1'b1, 1'b0);
    step();
    we = '0;
    set_all(2'b00, '0, 1'b0, '0);
    step(); step();
    // R6: halt collides with blocked conditions
    set_all(2'b11, '0, 1'b0, '1);
    step();
    write_all(1'b0, 1'b0);
    set_all(2'b11, '0, 1'b0, '1);
    step();
    we = '0;
    set_all(2'b01, '0, 1'b0, '1);
    step();
    set_all(2'b01, 4'b0101, 1'b0, 4'b0011);
    step(); step();
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      priv  = $urandom;
      men   = $urandom;
      men_sh = $urandom;
      halt  = (($urandom % 4) == 0) ? N'($urandom) : '0;
      we    = N'($urandom) & N'($urandom);
      for (int h = 0; h < N; h++) wdata[W*h +: W] = {$urandom, $urandom};
      step();
    end
    we = '0;
    step(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule